// File: doc/BRIEF.md
# Two-loop digital AGC controller

This controller chooses the gain index that a burst receiver applies to its antenna paths while the short training preamble is arriving. After a start pulse it loads a programmable initial index. It then sums the magnitudes of the in-phase and quadrature parts of every antenna over a fixed window of valid samples and turns the mean into a logarithm in 3 dB units. From that value it decides how to move the gain.

Two update paths share the gain register. If the saturation flag is raised while a window is being measured, the measurement is dropped on that cycle and the index is cut by a programmable coarse step. Otherwise a fine correction moves the index by the log-domain distance to a programmable target, and it backs off by an extra programmable amount when the signal is too strong. Each change is followed by a settle period counted in valid samples. A hit on the target, or an iteration cap, ends the run. The index then holds, with the done flag high, until the next start or until the enable is dropped.

States: `ST_IDLE` (waiting), `ST_MEASURE` (window accumulation), `ST_LARGE` (coarse cut), `ST_FINE` (log-domain correction), `ST_SETTLE` (post-change wait), `ST_DONE` (holding). Transitions:
- IDLE→MEASURE and DONE→MEASURE on start.
- MEASURE→LARGE on saturation.
- MEASURE→FINE on the last window sample.
- LARGE/FINE→SETTLE, or →DONE on the cap.
- FINE→DONE on target.
- SETTLE→MEASURE when the settle count is reached.
- Any state→IDLE when enable is low.

Top module: `two_loop_agc`

## Requirements
- R1: After reset, gain_idx is 0 and done is 0.
- R2: While enable is low the controller is idle: done is 0, gain_idx keeps its value, and start has no effect.
- R3: A start pulse with enable high, given in idle or done, loads gain_idx with min(cfg_gain_init, 32) on the next edge and opens a 32-sample window. Only cycles with samp_valid high count toward the window.
- R4: The window result is the sum of |I| and |Q| over both antennas (two's complement samples, antenna 0 in the low 12 bits of samp_i/samp_q) over 32 samples, divided by 128 and truncated to a mean M. The log value is 2·p + b, where p is the position of the leading one of M and b is the bit just below it (0 if M ≤ 1).
- R5: If the log value L is below cfg_target, gain_idx rises by cfg_target − L, clamped at 32.
- R6: If L is above cfg_target, gain_idx falls by (L − cfg_target) + cfg_small_step, clamped at 0.
- R7: If L equals cfg_target, gain_idx is unchanged and done rises.
- R8: sat_flag high in any measuring cycle abandons the window. On the following edge gain_idx falls by cfg_large_step, clamped at 0, and this counts as one iteration.
- R9: After each gain change the controller consumes cfg_settle valid samples before the next window, or none when cfg_settle is 0. gain_idx does not change while settling or measuring.
- R10: After MAX_ITER (6) gain changes the controller enters done and holds the last gain.
- R11: In done, gain_idx is stable until the next start. A start given while measuring, settling or updating is ignored.
- R12: gain_idx never exceeds 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable; low forces idle |
| start | input | 1 | Start pulse for a new acquisition |
| samp_valid | input | 1 | Sample strobe |
| samp_i | input | 24 | In-phase samples, antenna 0 in bits 11:0 |
| samp_q | input | 24 | Quadrature samples, antenna 0 in bits 11:0 |
| sat_flag | input | 1 | Converter saturation indication |
| cfg_gain_init | input | 6 | Initial gain index |
| cfg_target | input | 6 | Target log level, 3 dB units |
| cfg_small_step | input | 4 | Extra backoff when too strong |
| cfg_large_step | input | 4 | Coarse cut on saturation |
| cfg_settle | input | 8 | Valid samples to wait after a change |
| gain_idx | output | 6 | Current gain index, 3 dB per step |
| done | output | 1 | Acquisition finished |

## Verification
The window is fed with constant magnitudes that give logs below, above and equal to the target. These separate the raise, back-off and done paths, and repeated windows reach both clamps and the iteration cap. Mixed-sign components and the most negative code test the magnitude and the fractional log bit. Interleaved invalid samples of large size show whether the window counts only strobed samples. Saturation pulses in mid-window, and enable or start pulses given in busy states, show the priority of the abort paths over the normal sequence.

// File: rtl/agc_pkg.sv
package agc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEASURE,
        ST_LARGE,
        ST_FINE,
        ST_SETTLE,
        ST_DONE
    } agc_state_t;
endpackage

// File: rtl/agc_power_acc.sv
module agc_power_acc #(
    parameter int SAMPLE_W = 12,
    parameter int N_ANT    = 2,
    parameter int WIN_LOG2 = 5,
    localparam int CMP_LOG2 = $clog2(2 * N_ANT),
    localparam int SUM_W    = SAMPLE_W + CMP_LOG2,
    localparam int ACC_W    = SUM_W + WIN_LOG2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      add,
    input  logic [N_ANT*SAMPLE_W-1:0] vec_i,
    input  logic [N_ANT*SAMPLE_W-1:0] vec_q,
    output logic [ACC_W-1:0]          acc,
    output logic                      last
);
    logic [SAMPLE_W-1:0] mag [2*N_ANT];
    logic [SUM_W-1:0]    sum;
    logic [ACC_W-1:0]    acc_q;
    logic [WIN_LOG2-1:0] cnt_q;

    for (genvar a = 0; a < N_ANT; a++) begin : g_mag
        logic [SAMPLE_W-1:0] ri, rq;
        assign ri = vec_i[a*SAMPLE_W +: SAMPLE_W];
        assign rq = vec_q[a*SAMPLE_W +: SAMPLE_W];
        assign mag[2*a]   = ri[SAMPLE_W-1] ? (~ri + 1'b1) : ri;
        assign mag[2*a+1] = rq[SAMPLE_W-1] ? (~rq + 1'b1) : rq;
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k < 2 * N_ANT; k++) begin
            sum = sum + SUM_W'(mag[k]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (add) begin
            acc_q <= acc_q + ACC_W'(sum);
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign acc  = acc_q;
    assign last = add && (&cnt_q);
endmodule

// File: rtl/agc_log_conv.sv
module agc_log_conv #(
    parameter int IN_W  = 19,
    parameter int SHIFT = 7,
    parameter int LOG_W = 6,
    localparam int MEAN_W = IN_W - SHIFT
) (
    input  logic [IN_W-1:0]  acc,
    output logic [LOG_W-1:0] log_val
);
    logic [MEAN_W-1:0] mean;
    int                pos;
    logic              frac;

    assign mean = MEAN_W'(acc >> SHIFT);

    always_comb begin
        pos  = 0;
        frac = 1'b0;
        for (int b = 1; b < MEAN_W; b++) begin
            if (mean[b]) begin
                pos  = b;
                frac = mean[b-1];
            end
        end
        log_val = LOG_W'(2 * pos + int'(frac));
    end
endmodule

// File: rtl/agc_gain_step.sv
module agc_gain_step #(
    parameter int GAIN_W   = 6,
    parameter int GAIN_MAX = 32,
    parameter int LOG_W    = 6,
    parameter int STEP_W   = 4
) (
    input  logic [GAIN_W-1:0] gain,
    input  logic [LOG_W-1:0]  pwr_log,
    input  logic [LOG_W-1:0]  target,
    input  logic [STEP_W-1:0] small_step,
    input  logic [STEP_W-1:0] large_step,
    input  logic              sel_large,
    output logic [GAIN_W-1:0] next_gain,
    output logic              on_target
);
    int g, d, r;

    always_comb begin
        g = int'(gain);
        d = int'(target) - int'(pwr_log);
        if (sel_large) begin
            r = g - int'(large_step);
        end else if (d > 0) begin
            r = g + d;
        end else if (d < 0) begin
            r = g + d - int'(small_step);
        end else begin
            r = g;
        end
        if (r < 0) begin
            r = 0;
        end else if (r > GAIN_MAX) begin
            r = GAIN_MAX;
        end
        next_gain = GAIN_W'(r);
        on_target = (d == 0);
    end
endmodule

// File: rtl/two_loop_agc.sv
module two_loop_agc
    import agc_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int N_ANT    = 2,
    parameter int WIN_LOG2 = 5,
    parameter int GAIN_MAX = 32,
    parameter int STEP_W   = 4,
    parameter int SETTLE_W = 8,
    parameter int MAX_ITER = 6,
    localparam int GAIN_W   = $clog2(GAIN_MAX + 1),
    localparam int LOG_W    = $clog2(2 * SAMPLE_W) + 1,
    localparam int CMP_LOG2 = $clog2(2 * N_ANT),
    localparam int ACC_W    = SAMPLE_W + CMP_LOG2 + WIN_LOG2,
    localparam int ITER_W   = $clog2(MAX_ITER + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      enable,
    input  logic                      start,
    input  logic                      samp_valid,
    input  logic [N_ANT*SAMPLE_W-1:0] samp_i,
    input  logic [N_ANT*SAMPLE_W-1:0] samp_q,
    input  logic                      sat_flag,
    input  logic [GAIN_W-1:0]         cfg_gain_init,
    input  logic [LOG_W-1:0]          cfg_target,
    input  logic [STEP_W-1:0]         cfg_small_step,
    input  logic [STEP_W-1:0]         cfg_large_step,
    input  logic [SETTLE_W-1:0]       cfg_settle,
    output logic [GAIN_W-1:0]         gain_idx,
    output logic                      done
);
    agc_state_t          state_q, state_d;
    logic [GAIN_W-1:0]   gain_q;
    logic [ITER_W-1:0]   loops_q;
    logic [SETTLE_W-1:0] settle_q;
    logic [ACC_W-1:0]    acc;
    logic                win_last;
    logic                acc_clear, acc_add;
    logic [LOG_W-1:0]    pwr_log;
    logic [GAIN_W-1:0]   step_gain;
    logic                on_target;
    logic                iter_hit;
    logic                settle_end;
    logic                restart;
    logic                do_update;
    logic [GAIN_W-1:0]   init_gain;

    agc_power_acc #(
        .SAMPLE_W (SAMPLE_W),
        .N_ANT    (N_ANT),
        .WIN_LOG2 (WIN_LOG2)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (acc_clear),
        .add   (acc_add),
        .vec_i (samp_i),
        .vec_q (samp_q),
        .acc   (acc),
        .last  (win_last)
    );

    agc_log_conv #(
        .IN_W  (ACC_W),
        .SHIFT (WIN_LOG2 + CMP_LOG2),
        .LOG_W (LOG_W)
    ) u_log (
        .acc     (acc),
        .log_val (pwr_log)
    );

    agc_gain_step #(
        .GAIN_W   (GAIN_W),
        .GAIN_MAX (GAIN_MAX),
        .LOG_W    (LOG_W),
        .STEP_W   (STEP_W)
    ) u_step (
        .gain       (gain_q),
        .pwr_log    (pwr_log),
        .target     (cfg_target),
        .small_step (cfg_small_step),
        .large_step (cfg_large_step),
        .sel_large  (state_q == ST_LARGE),
        .next_gain  (step_gain),
        .on_target  (on_target)
    );

    assign iter_hit   = (loops_q + 1'b1) == ITER_W'(MAX_ITER);
    assign settle_end = (cfg_settle == '0) ||
                        (samp_valid && ((settle_q + 1'b1) >= cfg_settle));
    assign init_gain  = (cfg_gain_init > GAIN_W'(GAIN_MAX)) ? GAIN_W'(GAIN_MAX)
                                                           : cfg_gain_init;

    // next-state decision
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    if (start) state_d = ST_MEASURE;
                ST_MEASURE: begin
                    if (sat_flag)      state_d = ST_LARGE;
                    else if (win_last) state_d = ST_FINE;
                end
                ST_LARGE:   state_d = iter_hit ? ST_DONE : ST_SETTLE;
                ST_FINE: begin
                    if (on_target || iter_hit) state_d = ST_DONE;
                    else                       state_d = ST_SETTLE;
                end
                ST_SETTLE:  if (settle_end) state_d = ST_MEASURE;
                ST_DONE:    if (start) state_d = ST_MEASURE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign restart   = enable && start && (state_q == ST_IDLE || state_q == ST_DONE);
    assign do_update = enable && ((state_q == ST_LARGE) ||
                                  (state_q == ST_FINE && !on_target));
    assign acc_clear = (state_d == ST_MEASURE) && (state_q != ST_MEASURE);
    assign acc_add   = enable && (state_q == ST_MEASURE) && samp_valid;

    // gain, iteration and settle registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gain_q   <= '0;
            loops_q  <= '0;
            settle_q <= '0;
        end else begin
            if (restart) begin
                gain_q  <= init_gain;
                loops_q <= '0;
            end else if (do_update) begin
                gain_q  <= step_gain;
                loops_q <= loops_q + 1'b1;
            end
            if (state_q != ST_SETTLE) begin
                settle_q <= '0;
            end else if (enable && samp_valid) begin
                settle_q <= settle_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        gain_idx = gain_q;
        done     = (state_q == ST_DONE);
    end
endmodule

// File: rtl/agc_ctrl_checker.sv
module agc_ctrl_checker
    import agc_pkg::*;
#(
    parameter int GAIN_W   = 6,
    parameter int GAIN_MAX = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              start,
    input logic              sat_flag,
    input logic [GAIN_W-1:0] cfg_gain_init,
    input logic [GAIN_W-1:0] gain_idx,
    input logic              done,
    input agc_state_t        state
);
    AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        gain_idx <= GAIN_W'(GAIN_MAX)); // R12

    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !done); // R2

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && enable && !start) |=> (done && $stable(gain_idx))); // R11

    AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && enable && start) |=>
        (gain_idx == (($past(cfg_gain_init) > GAIN_W'(GAIN_MAX)) ?
                      GAIN_W'(GAIN_MAX) : $past(cfg_gain_init)))); // R3

    AST_SAT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MEASURE && enable && sat_flag) |=> (state == ST_LARGE)); // R8

    AST_GAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MEASURE || state == ST_SETTLE) |=> $stable(gain_idx)); // R9
endmodule

bind two_loop_agc agc_ctrl_checker #(
    .GAIN_W   (GAIN_W),
    .GAIN_MAX (GAIN_MAX)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .start         (start),
    .sat_flag      (sat_flag),
    .cfg_gain_init (cfg_gain_init),
    .gain_idx      (gain_idx),
    .done          (done),
    .state         (state_q)
);

// File: tb/two_loop_agc_tb.sv
module two_loop_agc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int MAXG = 32;
    localparam int NITER = 6;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        enable = 0;
    logic        start = 0;
    logic        samp_valid = 0;
    logic [23:0] samp_i = '0;
    logic [23:0] samp_q = '0;
    logic        sat_flag = 0;
    logic [5:0]  cfg_gain_init = 6'd20;
    logic [5:0]  cfg_target = 6'd13;
    logic [3:0]  cfg_small_step = 4'd1;
    logic [3:0]  cfg_large_step = 4'd6;
    logic [7:0]  cfg_settle = 8'd4;
    logic [5:0]  gain_idx;
    logic        done;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    two_loop_agc u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
        .samp_valid(samp_valid), .samp_i(samp_i), .samp_q(samp_q),
        .sat_flag(sat_flag), .cfg_gain_init(cfg_gain_init),
        .cfg_target(cfg_target), .cfg_small_step(cfg_small_step),
        .cfg_large_step(cfg_large_step), .cfg_settle(cfg_settle),
        .gain_idx(gain_idx), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference: 0 idle, 1 measure, 2 coarse, 3 fine, 4 settle, 5 done
    int m_st = 0, m_gain = 0, m_loops = 0, m_acc = 0, m_cnt = 0, m_set = 0;

    function automatic int mag12(logic [11:0] v);
        int s;
        s = $signed(v);
        return (s < 0) ? -s : s;
    endfunction

    function automatic int ref_log(int total);
        int m, p;
        m = total / 128;
        if (m <= 1) return 0;
        p = 0;
        while ((m >> (p + 1)) != 0) p++;
        return 2 * p + ((m >> (p - 1)) & 1);
    endfunction

    function automatic int clampg(int g);
        if (g < 0) return 0;
        if (g > MAXG) return MAXG;
        return g;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        int lg;
        if (!rst_n) begin
            m_st = 0; m_gain = 0; m_loops = 0; m_acc = 0; m_cnt = 0; m_set = 0;
        end else if (!enable) begin
            m_st = 0;
        end else begin
            case (m_st)
                0, 5: if (start) begin
                    m_gain = clampg(int'(cfg_gain_init));
                    m_loops = 0; m_acc = 0; m_cnt = 0; m_st = 1;
                end
                1: if (sat_flag) m_st = 2;
                   else if (samp_valid) begin
                       m_acc += mag12(samp_i[11:0]) + mag12(samp_q[11:0]) +
                                mag12(samp_i[23:12]) + mag12(samp_q[23:12]);
                       m_cnt++;
                       if (m_cnt == 32) m_st = 3;
                   end
                2: begin
                    m_gain = clampg(m_gain - int'(cfg_large_step));
                    m_loops++; m_set = 0;
                    m_st = (m_loops == NITER) ? 5 : 4;
                end
                3: begin
                    lg = ref_log(m_acc);
                    if (lg == int'(cfg_target)) m_st = 5;
                    else begin
                        if (lg < int'(cfg_target)) m_gain = clampg(m_gain + int'(cfg_target) - lg);
                        else m_gain = clampg(m_gain - (lg - int'(cfg_target)) - int'(cfg_small_step));
                        m_loops++; m_set = 0;
                        m_st = (m_loops == NITER) ? 5 : 4;
                    end
                end
                4: if (cfg_settle == 0) begin
                       m_st = 1; m_acc = 0; m_cnt = 0;
                   end else if (samp_valid) begin
                       m_set++;
                       if (m_set >= int'(cfg_settle)) begin
                           m_st = 1; m_acc = 0; m_cnt = 0;
                       end
                   end
                default: m_st = 0;
            endcase
        end
    end

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            n_checks++;
            if (gain_idx !== 6'(m_gain) || done !== (m_st == 5)) begin
                n_fail++;
                $display("FAIL cycle model (R3 R5 R6 R8 R9 R10): gain=%0d done=%0b expected gain=%0d done=%0b",
                         gain_idx, done, m_gain, (m_st == 5));
            end
        end
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected under 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_all(int a, int b, int c, int d);
        samp_i = {12'(c), 12'(a)};
        samp_q = {12'(d), 12'(b)};
    endtask

    task automatic feed(int n, int v, bit vld);
        repeat (n) begin
            @(negedge clk);
            samp_valid = vld;
            set_all(v, v, v, v);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        samp_valid = 0;
        start = 1;
        @(negedge clk);
        start = 0;
    endtask

    task automatic run_until_done(int v);
        for (int k = 0; k < 3000 && !done; k++) feed(1, v, 1);
        samp_valid = 0;
    endtask

    task automatic cycle_enable();
        @(negedge clk); enable = 0;
        @(negedge clk); enable = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset gain", gain_idx, 0);
        check("R1 reset done", done, 0);
        rst_n = 1;
        enable = 1;

        // R3 R4 R5: window of 16s, invalid cycles carry large values
        pulse_start();
        for (int k = 0; k < 32; k++) begin
            feed(1, 16, 1);
            feed(1, 2000, 0);
        end
        feed(20, 2000, 0);
        check("R3 R5 first fine raise", gain_idx, 25);
        check("R9 no valid while settling keeps done low", done, 0);
        run_until_done(16);
        check("R5 R10 clamp at top after cap", gain_idx, 32);
        check("R10 done after cap", done, 1);
        feed(30, 16, 1);
        check("R11 done holds gain", gain_idx, 32);
        check("R11 done stays", done, 1);

        // R6: too strong
        pulse_start();
        feed(32, 256, 1);
        feed(3, 0, 0);
        check("R6 fine cut with backoff", gain_idx, 16);
        run_until_done(256);
        check("R6 R10 clamp at zero", gain_idx, 0);

        // R7: on target
        pulse_start();
        feed(32, 96, 1);
        feed(2, 0, 0);
        check("R7 done on target", done, 1);
        check("R7 gain unchanged", gain_idx, 20);

        // R4: mixed signs, fractional bit zero
        pulse_start();
        for (int k = 0; k < 32; k++) begin
            @(negedge clk); samp_valid = 1; set_all(100, -100, 50, -50);
        end
        feed(2, 0, 0);
        check("R4 mixed sign log 12", gain_idx, 21);
        pulse_start();
        feed(3, 0, 0);
        check("R11 start while settling ignored", gain_idx, 21);
        cycle_enable();
        check("R2 enable low clears done path", done, 0);

        // R4: most negative code
        pulse_start();
        feed(32, -2048, 1);
        feed(2, 0, 0);
        check("R4 R6 full scale negative", gain_idx, 10);
        cycle_enable();

        // R4 R5: silence
        pulse_start();
        feed(32, 0, 1);
        feed(2, 0, 0);
        check("R4 R5 zero input clamps high", gain_idx, 32);
        cycle_enable();

        // R8: saturation mid-window
        pulse_start();
        feed(10, 16, 1);
        @(negedge clk); sat_flag = 1;
        @(negedge clk); sat_flag = 0;
        feed(2, 16, 0);
        check("R8 coarse cut", gain_idx, 14);
        sat_flag = 1;
        run_until_done(16);
        sat_flag = 0;
        check("R8 R10 coarse cuts to zero", gain_idx, 0);
        check("R8 R10 done", done, 1);

        // R2: enable drop mid-window, start ignored while disabled
        pulse_start();
        feed(10, 16, 1);
        @(negedge clk); enable = 0; samp_valid = 0; cfg_gain_init = 6'd5;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        feed(3, 0, 0);
        check("R2 gain held while disabled", gain_idx, 20);
        check("R2 done low while disabled", done, 0);
        @(negedge clk); enable = 1;
        pulse_start();
        check("R3 init load", gain_idx, 5);
        cfg_gain_init = 6'd40;
        cycle_enable();
        pulse_start();
        check("R3 init clamped", gain_idx, 32);

        // R9: zero settle count, back-to-back windows
        cfg_gain_init = 6'd20;
        cfg_settle = 8'd0;
        cycle_enable();
        pulse_start();
        run_until_done(16);
        check("R9 zero settle reaches cap", gain_idx, 32);
        check("R9 zero settle done", done, 1);

        feed(5, 0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule